// File: doc/BRIEF.md
# Fast Kernel-to-User Return Unit

This block carries out the checks and state updates of a fast return from kernel code to user code in a 64-bit processor model. On an issue strobe it samples the current code-segment long-mode bit, the long-mode-active and fast-call-enable control bits, the current privilege level, the return-address register, the saved-flags register, the operand size and a 16-bit selector base field. One cycle later it raises a done pulse together with either a single fault code or a fresh set of user-mode state: flags, privilege level, code and stack selectors and instruction pointer.

Faults are checked in a fixed order: invalid opcode first, then privilege, then a canonical-address test on the return target. When a fault is reported the state outputs keep their previous values, so a pipeline that consumes them sees no partial update. Decoding, descriptor loading and paging are handled elsewhere.

Top module: `fast_ret_unit`

## Requirements
- R1: If any of cs_long_i, lm_active_i or fastcall_en_i is 0, the result carries fault_o = 2'd1 (invalid opcode).
- R2: With R1 not raised and cpl_i not 0, the result carries fault_o = 2'd2 (general protection, error code zero).
- R3: With R1 and R2 not raised, the result carries fault_o = 2'd2 when ret_addr_i bits 63:47 are not all equal (non-canonical); this test applies in both operand sizes.
- R4: Only the highest-priority fault is reported, and on any fault flags_o, cpl_o, cs_sel_o, ss_sel_o and ip_o keep their previous values.
- R5: On success with op64_i = 1, cs_sel_o = sel_base_i + 16 with bits 1:0 set to 3, and ip_o = ret_addr_i.
- R6: On success with op64_i = 0, cs_sel_o = sel_base_i with bits 1:0 set to 3, and ip_o = ret_addr_i[31:0] zero-extended.
- R7: On success in either size, ss_sel_o = sel_base_i + 8 with bits 1:0 set to 3.
- R8: On success, flags_o = saved_flags_i and cpl_o = 3, with fault_o = 2'd0.
- R9: The selector sums wrap modulo 2^16.
- R10: done_o is high for exactly the cycle after each cycle in which start_i is sampled high; after reset done_o, fault_o and all state outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue strobe, samples all operands |
| cs_long_i | input | 1 | Current code segment is in 64-bit mode |
| lm_active_i | input | 1 | Long mode active |
| fastcall_en_i | input | 1 | Fast system-call instructions enabled |
| cpl_i | input | 2 | Current privilege level |
| ret_addr_i | input | 64 | Return-address register |
| saved_flags_i | input | 64 | Saved-flags register |
| op64_i | input | 1 | 1: 64-bit operand size, 0: compatibility return |
| sel_base_i | input | 16 | Selector base field of the call-target register |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| flags_o | output | 64 | Restored flags |
| cpl_o | output | 2 | New privilege level |
| cs_sel_o | output | 16 | New code selector |
| ss_sel_o | output | 16 | New stack selector |
| ip_o | output | 64 | New instruction pointer |

## Verification
The functions that coincide are the three fault checks: a single issue can be disabled, privileged and non-canonical at once. The bench drives operand sets in which two or all three conditions hold together and expects exactly the highest-ranked code, with every state output still equal to the last successful return. Back-to-back issues interleave faults and successes so that a held value and a fresh update land in adjacent cycles.

// File: rtl/fast_ret_pkg.sv
package fast_ret_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  localparam logic [1:0] USER_PL = 2'd3;
endpackage

// File: rtl/fast_ret_fault_chk.sv
module fast_ret_fault_chk
  import fast_ret_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned VA_BITS = 48
) (
  input  logic              cs_long_i,
  input  logic              lm_active_i,
  input  logic              fastcall_en_i,
  input  logic [1:0]        cpl_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  output fault_e            fault_o
);
  logic canon;

  generate
    if (VA_BITS >= ADDR_W) begin : g_full_va
      assign canon = 1'b1;
    end else begin : g_sign_ext
      localparam int unsigned HI_W = ADDR_W - VA_BITS + 1;
      logic [HI_W-1:0] hi_bits;
      assign hi_bits = ret_addr_i[ADDR_W-1:VA_BITS-1];
      assign canon   = (&hi_bits) | ~(|hi_bits);
    end
  endgenerate

  // fixed priority: mode/enable, then privilege, then target address
  always_comb begin
    if (!(cs_long_i && lm_active_i && fastcall_en_i)) fault_o = FLT_UD;
    else if (cpl_i != 2'd0)                           fault_o = FLT_GP;
    else if (!canon)                                  fault_o = FLT_GP;
    else                                              fault_o = FLT_NONE;
  end
endmodule

// File: rtl/fast_ret_target_gen.sv
module fast_ret_target_gen
  import fast_ret_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned COMPAT_W = 32,
  parameter int unsigned CS64_OFS = 16,
  parameter int unsigned SS_OFS   = 8
) (
  input  logic              op64_i,
  input  logic [SEL_W-1:0]  sel_base_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  output logic [SEL_W-1:0]  cs_sel_o,
  output logic [SEL_W-1:0]  ss_sel_o,
  output logic [ADDR_W-1:0] ip_o
);
  localparam logic [SEL_W-1:0] CS_ADD = SEL_W'(CS64_OFS);
  localparam logic [SEL_W-1:0] SS_ADD = SEL_W'(SS_OFS);

  logic [SEL_W-1:0] cs_sum, ss_sum;

  assign cs_sum   = sel_base_i + (op64_i ? CS_ADD : '0);
  assign ss_sum   = sel_base_i + SS_ADD;
  assign cs_sel_o = {cs_sum[SEL_W-1:2], USER_PL};
  assign ss_sel_o = {ss_sum[SEL_W-1:2], USER_PL};
  assign ip_o     = op64_i ? ret_addr_i : ADDR_W'(ret_addr_i[COMPAT_W-1:0]);
endmodule

// File: rtl/fast_ret_state_reg.sv
module fast_ret_state_reg
  import fast_ret_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned FLAGS_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  fault_e             fault_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [SEL_W-1:0]   cs_sel_i,
  input  logic [SEL_W-1:0]   ss_sel_i,
  input  logic [ADDR_W-1:0]  ip_i,
  output logic               done_o,
  output fault_e             fault_o,
  output logic [FLAGS_W-1:0] flags_o,
  output logic [1:0]         cpl_o,
  output logic [SEL_W-1:0]   cs_sel_o,
  output logic [SEL_W-1:0]   ss_sel_o,
  output logic [ADDR_W-1:0]  ip_o
);
  logic commit;
  assign commit = start_i && (fault_i == FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      fault_o <= FLT_NONE;
    end else begin
      done_o  <= start_i;
      if (start_i) fault_o <= fault_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o  <= '0;
      cpl_o    <= 2'd0;
      cs_sel_o <= '0;
      ss_sel_o <= '0;
      ip_o     <= '0;
    end else if (commit) begin
      flags_o  <= flags_i;
      cpl_o    <= USER_PL;
      cs_sel_o <= cs_sel_i;
      ss_sel_o <= ss_sel_i;
      ip_o     <= ip_i;
    end
  end

  a_r4_hold_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && fault_i != FLT_NONE) |=>
      ($stable(flags_o) && $stable(cpl_o) && $stable(cs_sel_o) &&
       $stable(ss_sel_o) && $stable(ip_o)));

  a_r10_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  a_r8_user_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_NONE) |-> (cpl_o == USER_PL));

  a_r7_sel_rpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_NONE) |-> (cs_sel_o[1:0] == USER_PL && ss_sel_o[1:0] == USER_PL));
endmodule

// File: rtl/fast_ret_unit.sv
module fast_ret_unit
  import fast_ret_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned VA_BITS  = 48,
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned FLAGS_W  = 64,
  parameter int unsigned COMPAT_W = 32,
  parameter int unsigned CS64_OFS = 16,
  parameter int unsigned SS_OFS   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cs_long_i,
  input  logic               lm_active_i,
  input  logic               fastcall_en_i,
  input  logic [1:0]         cpl_i,
  input  logic [ADDR_W-1:0]  ret_addr_i,
  input  logic [FLAGS_W-1:0] saved_flags_i,
  input  logic               op64_i,
  input  logic [SEL_W-1:0]   sel_base_i,
  output logic               done_o,
  output logic [1:0]         fault_o,
  output logic [FLAGS_W-1:0] flags_o,
  output logic [1:0]         cpl_o,
  output logic [SEL_W-1:0]   cs_sel_o,
  output logic [SEL_W-1:0]   ss_sel_o,
  output logic [ADDR_W-1:0]  ip_o
);
  fault_e            fault_nxt, fault_q;
  logic [SEL_W-1:0]  cs_nxt, ss_nxt;
  logic [ADDR_W-1:0] ip_nxt;

  fast_ret_fault_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_chk (
    .cs_long_i    (cs_long_i),
    .lm_active_i  (lm_active_i),
    .fastcall_en_i(fastcall_en_i),
    .cpl_i        (cpl_i),
    .ret_addr_i   (ret_addr_i),
    .fault_o      (fault_nxt)
  );

  fast_ret_target_gen #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .COMPAT_W(COMPAT_W),
    .CS64_OFS(CS64_OFS), .SS_OFS(SS_OFS)
  ) u_tgt (
    .op64_i    (op64_i),
    .sel_base_i(sel_base_i),
    .ret_addr_i(ret_addr_i),
    .cs_sel_o  (cs_nxt),
    .ss_sel_o  (ss_nxt),
    .ip_o      (ip_nxt)
  );

  fast_ret_state_reg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .FLAGS_W(FLAGS_W)) u_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .fault_i (fault_nxt),
    .flags_i (saved_flags_i),
    .cs_sel_i(cs_nxt),
    .ss_sel_i(ss_nxt),
    .ip_i    (ip_nxt),
    .done_o  (done_o),
    .fault_o (fault_q),
    .flags_o (flags_o),
    .cpl_o   (cpl_o),
    .cs_sel_o(cs_sel_o),
    .ss_sel_o(ss_sel_o),
    .ip_o    (ip_o)
  );

  assign fault_o = fault_q;

  a_r1_ud_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(cs_long_i && lm_active_i && fastcall_en_i)) |=> (fault_o == 2'd1));

  a_r2_priv_gp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cs_long_i && lm_active_i && fastcall_en_i && cpl_i != 2'd0) |=> (fault_o == 2'd2));

  a_r8_flags_restored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && fault_nxt == FLT_NONE) |=> (flags_o == $past(saved_flags_i)));

  a_r6_compat_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op64_i && fault_nxt == FLT_NONE) |=> (ip_o[ADDR_W-1:COMPAT_W] == '0));
endmodule

// File: tb/fast_ret_unit_tb.sv
module fast_ret_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cs_long = 1'b0, lma = 1'b0, en = 1'b0;
  logic [1:0]  cpl = '0;
  logic [63:0] ret = '0, sflags = '0;
  logic        op64 = 1'b0;
  logic [15:0] base = '0;

  logic        done;
  logic [1:0]  fault, cpl_o;
  logic [63:0] flags_o, ip_o;
  logic [15:0] cs_o, ss_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fast_ret_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cs_long_i(cs_long), .lm_active_i(lma), .fastcall_en_i(en),
    .cpl_i(cpl), .ret_addr_i(ret), .saved_flags_i(sflags),
    .op64_i(op64), .sel_base_i(base),
    .done_o(done), .fault_o(fault), .flags_o(flags_o), .cpl_o(cpl_o),
    .cs_sel_o(cs_o), .ss_sel_o(ss_o), .ip_o(ip_o)
  );

  typedef struct {
    logic [1:0]  fault;
    logic [63:0] flags;
    logic [1:0]  cpl;
    logic [15:0] cs, ss;
    logic [63:0] ip;
    string       req;
  } item_t;

  item_t q[$];
  item_t model;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // driver: computes expected result from the requirements, queues it, issues
  task automatic issue(input logic l, input logic a, input logic e, input logic [1:0] pl,
                       input logic [63:0] ra, input logic [63:0] fl, input logic o64,
                       input logic [15:0] b, input string req);
    item_t it;
    bit canon;
    logic [15:0] c, s;
    canon = (ra[63:47] == '0) || (ra[63:47] == '1);
    it = model;
    it.req = req;
    if (!(l && a && e))   it.fault = 2'd1;
    else if (pl != 2'd0)  it.fault = 2'd2;
    else if (!canon)      it.fault = 2'd2;
    else begin
      c = o64 ? b + 16'd16 : b;
      s = b + 16'd8;
      it.fault = 2'd0;
      it.flags = fl;
      it.cpl   = 2'd3;
      it.cs    = c | 16'h3;
      it.ss    = s | 16'h3;
      it.ip    = o64 ? ra : {32'h0, ra[31:0]};
      model = it;
    end
    @(negedge clk);
    #1;
    cs_long = l; lma = a; en = e; cpl = pl; ret = ra; sflags = fl; op64 = o64; base = b;
    start = 1'b1;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    item_t x;
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "done without issue", 64'(done), 64'h0);
        end else begin
          x = q.pop_front();
          chk(fault === x.fault, x.req, "fault", 64'(fault), 64'(x.fault));
          chk(flags_o === x.flags, x.req, "flags", flags_o, x.flags);
          chk(cpl_o === x.cpl, x.req, "cpl", 64'(cpl_o), 64'(x.cpl));
          chk(cs_o === x.cs, x.req, "cs", 64'(cs_o), 64'(x.cs));
          chk(ss_o === x.ss, x.req, "ss", 64'(ss_o), 64'(x.ss));
          chk(ip_o === x.ip, x.req, "ip", ip_o, x.ip);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model = '{fault: 2'd0, flags: '0, cpl: 2'd0, cs: '0, ss: '0, ip: '0, req: ""};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done === 1'b0, "R10", "reset done", 64'(done), 64'h0);
    chk(fault === 2'd0, "R10", "reset fault", 64'(fault), 64'h0);
    chk({flags_o, ip_o} === '0 && cs_o === '0 && ss_o === '0 && cpl_o === '0,
        "R10", "reset state", ip_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(1,1,1,0, 64'h0000_7FFF_0000_1000, 64'h0000_0000_0000_0246, 1, 16'h0020, "R5 R7 R8");
    issue(1,1,1,0, 64'hFFFF_8000_1234_5678, 64'h0000_0000_0000_0202, 0, 16'h0020, "R6 R7 R8");
    issue(0,1,1,0, 64'h0000_0000_0000_4000, 64'h1, 1, 16'h0100, "R1 cs_long");
    issue(1,0,1,0, 64'h0000_0000_0000_4000, 64'h1, 1, 16'h0100, "R1 lm_active");
    issue(1,1,0,0, 64'h0000_0000_0000_4000, 64'h1, 1, 16'h0100, "R1 enable");
    issue(1,1,1,1, 64'h0000_0000_0000_4000, 64'h1, 1, 16'h0100, "R2 cpl1");
    issue(1,1,1,3, 64'h0000_0000_0000_4000, 64'h1, 0, 16'h0100, "R2 cpl3");
    issue(1,1,1,0, 64'h0000_8000_0000_0000, 64'h1, 1, 16'h0100, "R3 low edge");
    issue(1,1,1,0, 64'hFFFF_7FFF_FFFF_FFFF, 64'h1, 1, 16'h0100, "R3 high edge");
    issue(1,1,1,0, 64'h8000_0000_0000_0000, 64'h1, 0, 16'h0100, "R3 compat");
    issue(1,1,1,0, 64'h0000_7FFF_FFFF_FFFF, 64'h0000_0000_0000_0A02, 1, 16'h0033, "R3 canon max R5");
    issue(1,1,1,0, 64'hFFFF_8000_0000_0000, 64'h0000_0000_0000_0003, 1, 16'h0040, "R3 canon min R5");
    issue(1,1,0,2, 64'h0123_0000_0000_0000, 64'h7, 1, 16'h0200, "R4 all three");
    issue(1,1,1,1, 64'h0123_0000_0000_0000, 64'h7, 1, 16'h0200, "R4 priv+addr");
    issue(1,1,1,0, 64'h0000_0000_00AB_CDEF, 64'h0000_0000_0000_0286, 1, 16'hFFF4, "R9 cs wrap");
    issue(1,1,1,0, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0000_0000_0000_0046, 0, 16'hFFFA, "R9 ss wrap R6");
    issue(0,0,0,3, 64'hFFFF_0000_0000_0000, 64'hF, 0, 16'h1111, "R4 hold");
    @(negedge clk);
    #1 start = 1'b0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "pending results", 64'(q.size()), 64'h0);
    chk(done === 1'b0, "R10", "idle done", 64'(done), 64'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule